// File: doc/BRIEF.md
# Ethernet MAC Control Register Bank

This block is the 32-bit control and status register bank of a descriptor-driven Ethernet MAC. It stores the operating mode word, the interrupt event and enable masks, the three inter-packet gap settings, the frame length limits, the collision settings, the transmit descriptor count, the management interface registers, the 48-bit station address and two hash words. Behind the registers sits a word-addressed window onto the descriptor RAM. The transmit and receive engines read their enables, frame length limits, descriptor count, receive descriptor pointer and station address straight from the block's outputs. The engines post events on a set-pulse input. A single interrupt line combines the posted events that are enabled.

The bus port accepts one access per cycle: address, write enable and write data. Read data follows the address combinationally in the same cycle. A small two-state sequencer controls the RAM. In state SCRUB it writes zero to one descriptor word per cycle and holds the engines in reset. In state READY the bank serves the bus normally. The transition SCRUB→READY happens as the last word is cleared. The transition READY→SCRUB happens on a mode write with the soft-reset bit set. After power-on reset the sequencer starts in SCRUB.

Top module: `emac_regfile`

## Requirements
- R1: After reset the registers read as follows. Mode (0x00) reads 0x0000A000. Gap registers 0x0C, 0x10 and 0x14 read 0x12, 0x0C and 0x12. Length limits (0x18) read 0x003C0600. Collision settings (0x1C) read 0x000F003F. Management mode (0x28) reads 0x64. Descriptor count (0x20) reads 0x40. Every other register reads zero: event mask 0x08, event flags 0x04, control mode 0x24, management command, address, write data, read data and status at 0x2C–0x3C, station address words 0x40/0x44, and hash words 0x48/0x4C. The two lowest address bits are ignored for register decoding.
- R2: The length register is split in two halves. Bits 31:16 drive `min_len_o` (60 after reset) and bits 15:0 drive `max_len_o` (1536 after reset).
- R3: Event flags (0x04, width INT_BITS) are set by a one on `irq_set_i`. A write clears exactly the flag bits written as one and leaves the others unchanged. A flag that is set and cleared in the same cycle stays set.
- R4: `irq_o` is high exactly when some event flag bit and the matching event mask (0x08) bit are both one.
- R5: A write to the descriptor count register (0x20) keeps only wdata[7:0]. It also loads `rx_desc_ptr_o` with that count shifted left by one bit (0x80 after reset). `tx_desc_cnt_o` shows the count.
- R6: Station address word 0x40 holds bytes 0..3, with byte 0 in bits 7:0. Word 0x44 keeps only bits 15:0, holding byte 4 in bits 7:0 and byte 5 in bits 15:8; its bits 31:16 read zero. `station_addr_o` carries byte 0 in bits 7:0 up to byte 5 in bits 47:40.
- R7: Byte addresses from 0x400 up to 0x7FC access descriptor RAM word (address − 0x400)/4, for reads and for writes.
- R8: Addresses that are neither a register (0x00–0x4C) nor inside the window read zero, and writes to them change nothing.
- R9: A mode write with bit 11 set restores every register and the receive pointer to the R1 defaults; mode reads back 0x0000A000. `engines_rst_o` then stays high for exactly 256 cycles while the descriptor RAM is cleared to zero.
- R10: While `engines_rst_o` is high, every read returns zero and every write is ignored.
- R11: `rx_en_o` follows mode bit 0 and `tx_en_o` follows mode bit 1.
- R12: After power-on reset is released, `engines_rst_o` stays high for exactly 256 cycles. Once it drops, all descriptor words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_set_i | input | INT_BITS | Event set pulses from the engines |
| irq_o | output | 1 | Combined enabled-event interrupt |
| tx_en_o | output | 1 | Transmit engine enable |
| rx_en_o | output | 1 | Receive engine enable |
| engines_rst_o | output | 1 | Engines held in reset while RAM is scrubbed |
| min_len_o | output | 16 | Minimum frame length |
| max_len_o | output | 16 | Maximum frame length |
| tx_desc_cnt_o | output | TXCNT_W | Transmit descriptor count |
| rx_desc_ptr_o | output | TXCNT_W+1 | First receive descriptor word index |
| station_addr_o | output | 48 | Station address, byte 0 lowest |

## Verification
The hardest situation to reach from the ports is a bus access that lands inside the scrub window. Such an access must be dropped, and the read must return zero even for registers whose default is nonzero. The stimulus first moves several registers and a descriptor word away from their defaults. It then issues the soft-reset write and, at once, a read and a write while `engines_rst_o` is high. It counts the cycles until READY and expects exactly 256. The same-cycle race between an engine's set pulse and a clearing write is produced by driving both in one bus cycle.

// File: rtl/emac_regfile_pkg.sv
package emac_regfile_pkg;

    localparam int NUM_REGS     = 20;
    localparam int REG_IDX_W    = 5;

    localparam int RI_MODE      = 0;
    localparam int RI_INT_SRC   = 1;
    localparam int RI_INT_MASK  = 2;
    localparam int RI_IPGT      = 3;
    localparam int RI_IPGR1     = 4;
    localparam int RI_IPGR2     = 5;
    localparam int RI_PKTLEN    = 6;
    localparam int RI_COLL      = 7;
    localparam int RI_TX_CNT    = 8;
    localparam int RI_MAC1      = 17;

    localparam int MODE_RX_EN_BIT   = 0;
    localparam int MODE_TX_EN_BIT   = 1;
    localparam int MODE_SOFT_RST_BIT = 11;

    localparam logic [31:0] MODE_DEF = 32'h0000_A000;

    typedef enum logic {
        ST_SCRUB,
        ST_READY
    } scrub_state_e;

    function automatic logic [31:0] reg_default(input int idx);
        case (idx)
            RI_MODE:   return MODE_DEF;
            RI_IPGT:   return 32'h0000_0012;
            RI_IPGR1:  return 32'h0000_000C;
            RI_IPGR2:  return 32'h0000_0012;
            RI_PKTLEN: return 32'h003C_0600;
            RI_COLL:   return 32'h000F_003F;
            RI_TX_CNT: return 32'h0000_0040;
            10:        return 32'h0000_0064;
            default:   return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/emac_scrub_fsm.sv
module emac_scrub_fsm
    import emac_regfile_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_req_i,
    output logic             scrub_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    scrub_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SCRUB;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_SCRUB: begin
                idx_d = idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    state_d = ST_READY;
                    idx_d   = '0;
                end
            end
            ST_READY: begin
                if (soft_req_i) begin
                    state_d = ST_SCRUB;
                    idx_d   = '0;
                end
            end
        endcase
    end

    always_comb begin
        scrub_o = (state_q == ST_SCRUB);
        idx_o   = idx_q;
    end

    // R9
    scrub_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && soft_req_i) |=> (state_q == ST_SCRUB && idx_q == '0));

    // R12
    scrub_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCRUB && idx_q != LAST_IDX) |=>
            (state_q == ST_SCRUB && idx_q == IDX_W'($past(idx_q) + 1'b1)));

endmodule

// File: rtl/emac_desc_ram.sv
module emac_desc_ram #(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [31:0]      wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [31:0]      rdata_o
);

    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[widx_i] <= wdata_i;
    end

    assign rdata_o = mem_q[ridx_i];

endmodule

// File: rtl/emac_csr.sv
module emac_csr
    import emac_regfile_pkg::*;
#(
    parameter int INT_BITS = 7,
    parameter int TXCNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_clr_i,
    input  logic                 wr_i,
    input  logic [REG_IDX_W-1:0] reg_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    input  logic [INT_BITS-1:0]  irq_set_i,
    output logic                 irq_o,
    output logic                 tx_en_o,
    output logic                 rx_en_o,
    output logic [15:0]          min_len_o,
    output logic [15:0]          max_len_o,
    output logic [TXCNT_W-1:0]   tx_desc_cnt_o,
    output logic [TXCNT_W:0]     rx_desc_ptr_o,
    output logic [47:0]          station_addr_o
);

    localparam logic [TXCNT_W:0] RXPTR_DEF = {reg_default(RI_TX_CNT)[TXCNT_W-1:0], 1'b0};

    logic [31:0]      regs_q [NUM_REGS];
    logic [TXCNT_W:0] rxptr_q;
    logic [31:0]      src_clr;
    logic [31:0]      src_next;

    assign src_clr  = (wr_i && reg_i == REG_IDX_W'(RI_INT_SRC)) ? wdata_i : 32'h0;
    assign src_next = (regs_q[RI_INT_SRC] & ~src_clr) | 32'(irq_set_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
            rxptr_q <= RXPTR_DEF;
        end else if (soft_clr_i) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
            rxptr_q <= RXPTR_DEF;
        end else begin
            if (wr_i) begin
                case (int'(reg_i))
                    RI_INT_SRC: ;
                    RI_TX_CNT: begin
                        regs_q[RI_TX_CNT] <= 32'(wdata_i[TXCNT_W-1:0]);
                        rxptr_q           <= {wdata_i[TXCNT_W-1:0], 1'b0};
                    end
                    RI_MAC1:   regs_q[RI_MAC1] <= {16'h0, wdata_i[15:0]};
                    default:   regs_q[reg_i]   <= wdata_i;
                endcase
            end
            regs_q[RI_INT_SRC] <= src_next;
        end
    end

    always_comb begin
        rdata_o = (int'(reg_i) < NUM_REGS) ? regs_q[reg_i] : 32'h0;
    end

    assign irq_o          = |(regs_q[RI_INT_SRC][INT_BITS-1:0] & regs_q[RI_INT_MASK][INT_BITS-1:0]);
    assign tx_en_o        = regs_q[RI_MODE][MODE_TX_EN_BIT];
    assign rx_en_o        = regs_q[RI_MODE][MODE_RX_EN_BIT];
    assign min_len_o      = regs_q[RI_PKTLEN][31:16];
    assign max_len_o      = regs_q[RI_PKTLEN][15:0];
    assign tx_desc_cnt_o  = regs_q[RI_TX_CNT][TXCNT_W-1:0];
    assign rx_desc_ptr_o  = rxptr_q;
    assign station_addr_o = {regs_q[RI_MAC1][15:0], regs_q[RI_MAC1 - 1]};

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && reg_i == REG_IDX_W'(RI_INT_SRC) && wdata_i[0] && !irq_set_i[0])
            |=> !regs_q[RI_INT_SRC][0]);

    // R3
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_i && reg_i == REG_IDX_W'(RI_INT_SRC)) && irq_set_i == '0 && !soft_clr_i)
            |=> $stable(regs_q[RI_INT_SRC]));

    // R5
    rxptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && reg_i == REG_IDX_W'(RI_TX_CNT) && !soft_clr_i)
            |=> rx_desc_ptr_o == {$past(wdata_i[TXCNT_W-1:0]), 1'b0});

    // R9
    soft_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr_i |=> (regs_q[RI_MODE] == MODE_DEF && rx_desc_ptr_o == RXPTR_DEF));

endmodule

// File: rtl/emac_regfile.sv
module emac_regfile
    import emac_regfile_pkg::*;
#(
    parameter int          ADDR_W     = 11,
    parameter int          DESC_COUNT = 128,
    parameter logic [31:0] WIN_BASE   = 32'h0000_0400,
    parameter int          INT_BITS   = 7,
    parameter int          TXCNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                we_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rdata_o,
    input  logic [INT_BITS-1:0] irq_set_i,
    output logic                irq_o,
    output logic                tx_en_o,
    output logic                rx_en_o,
    output logic                engines_rst_o,
    output logic [15:0]         min_len_o,
    output logic [15:0]         max_len_o,
    output logic [TXCNT_W-1:0]  tx_desc_cnt_o,
    output logic [TXCNT_W:0]    rx_desc_ptr_o,
    output logic [47:0]         station_addr_o
);

    localparam int          DESC_WORDS = 2 * DESC_COUNT;
    localparam int          IDX_W      = $clog2(DESC_WORDS);
    localparam logic [31:0] WIN_END    = WIN_BASE + 32'(4 * DESC_WORDS);

    logic [ADDR_W-3:0]    word_addr;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 reg_hit;
    logic                 win_hit;
    logic [IDX_W-1:0]     win_idx;
    logic                 scrub;
    logic [IDX_W-1:0]     scrub_idx;
    logic                 csr_wr;
    logic                 soft_req;
    logic [31:0]          csr_rdata;
    logic                 ram_we;
    logic [IDX_W-1:0]     ram_widx;
    logic [31:0]          ram_wdata;
    logic [31:0]          ram_rdata;

    assign word_addr = addr_i[ADDR_W-1:2];
    assign reg_idx   = word_addr[REG_IDX_W-1:0];
    assign reg_hit   = (int'(word_addr) < NUM_REGS);
    assign win_hit   = (32'(addr_i) >= WIN_BASE) && (32'(addr_i) < WIN_END);
    assign win_idx   = IDX_W'((32'(addr_i) - WIN_BASE) >> 2);

    assign csr_wr    = we_i && !scrub && reg_hit;
    assign soft_req  = csr_wr && reg_idx == REG_IDX_W'(RI_MODE) && wdata_i[MODE_SOFT_RST_BIT];

    assign ram_we    = scrub || (we_i && win_hit && !reg_hit);
    assign ram_widx  = scrub ? scrub_idx : win_idx;
    assign ram_wdata = scrub ? 32'h0 : wdata_i;

    always_comb begin
        if (scrub)        rdata_o = 32'h0;
        else if (reg_hit) rdata_o = csr_rdata;
        else if (win_hit) rdata_o = ram_rdata;
        else              rdata_o = 32'h0;
    end

    assign engines_rst_o = scrub;

    emac_scrub_fsm #(.WORDS(DESC_WORDS), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_req_i (soft_req),
        .scrub_o    (scrub),
        .idx_o      (scrub_idx)
    );

    emac_desc_ram #(.WORDS(DESC_WORDS), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .we_i    (ram_we),
        .widx_i  (ram_widx),
        .wdata_i (ram_wdata),
        .ridx_i  (win_idx),
        .rdata_o (ram_rdata)
    );

    emac_csr #(.INT_BITS(INT_BITS), .TXCNT_W(TXCNT_W)) u_csr (
        .clk            (clk),
        .rst_n          (rst_n),
        .soft_clr_i     (soft_req),
        .wr_i           (csr_wr),
        .reg_i          (reg_idx),
        .wdata_i        (wdata_i),
        .rdata_o        (csr_rdata),
        .irq_set_i      (irq_set_i),
        .irq_o          (irq_o),
        .tx_en_o        (tx_en_o),
        .rx_en_o        (rx_en_o),
        .min_len_o      (min_len_o),
        .max_len_o      (max_len_o),
        .tx_desc_cnt_o  (tx_desc_cnt_o),
        .rx_desc_ptr_o  (rx_desc_ptr_o),
        .station_addr_o (station_addr_o)
    );

endmodule

// File: tb/emac_regfile_tb.sv
`timescale 1ns/1ps
module emac_regfile_tb;

    localparam logic [10:0] A_MODE  = 11'h000;
    localparam logic [10:0] A_SRC   = 11'h004;
    localparam logic [10:0] A_MASK  = 11'h008;
    localparam logic [10:0] A_IPGT  = 11'h00C;
    localparam logic [10:0] A_IPGR1 = 11'h010;
    localparam logic [10:0] A_IPGR2 = 11'h014;
    localparam logic [10:0] A_PLEN  = 11'h018;
    localparam logic [10:0] A_COLL  = 11'h01C;
    localparam logic [10:0] A_TXCNT = 11'h020;
    localparam logic [10:0] A_MIIM  = 11'h028;
    localparam logic [10:0] A_MAC0  = 11'h040;
    localparam logic [10:0] A_MAC1  = 11'h044;
    localparam logic [10:0] A_HASH0 = 11'h048;
    localparam logic [10:0] A_HASH1 = 11'h04C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  irq_set = '0;
    logic        irq, tx_en, rx_en, eng_rst;
    logic [15:0] min_len, max_len;
    logic [7:0]  tx_cnt;
    logic [8:0]  rx_ptr;
    logic [47:0] st_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    emac_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .irq_set_i(irq_set), .irq_o(irq), .tx_en_o(tx_en),
        .rx_en_o(rx_en), .engines_rst_o(eng_rst), .min_len_o(min_len),
        .max_len_o(max_len), .tx_desc_cnt_o(tx_cnt), .rx_desc_ptr_o(rx_ptr),
        .station_addr_o(st_addr)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        addr = a; we = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin : monitor
        logic [31:0] e;
        string t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s: actual %0h expected %0h", t, rdata, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(eng_rst, 1, "R12 engines held after reset");
        n = 0;
        while (eng_rst && n < 1000) begin @(posedge clk); #1; n++; end
        chk(n, 256, "R12 scrub length after reset");

        // R1 defaults
        rd(A_MODE,  32'h0000_A000, "R1 mode default");
        rd(A_SRC,   32'h0,         "R1 flags default");
        rd(A_MASK,  32'h0,         "R1 mask default");
        rd(A_IPGT,  32'h12,        "R1 ipgt default");
        rd(A_IPGR1, 32'h0C,        "R1 ipgr1 default");
        rd(A_IPGR2, 32'h12,        "R1 ipgr2 default");
        rd(A_PLEN,  32'h003C_0600, "R1 length default");
        rd(A_COLL,  32'h000F_003F, "R1 collision default");
        rd(A_TXCNT, 32'h40,        "R1 count default");
        rd(A_MIIM,  32'h64,        "R1 mgmt mode default");
        rd(A_MAC0,  32'h0,         "R1 station0 default");
        rd(A_HASH1, 32'h0,         "R1 hash1 default");
        @(posedge clk); #1;
        chk(min_len, 16'd60,   "R2 min default");
        chk(max_len, 16'd1536, "R2 max default");
        chk(rx_ptr, 9'h80,     "R5 rx pointer default");
        chk(tx_cnt, 8'h40,     "R5 tx count default");
        chk({tx_en, rx_en}, 2'b00, "R11 enables default");
        chk(irq, 0, "R4 irq default");

        // R12 RAM cleared, R7 window
        rd(11'h400, 32'h0, "R12 first descriptor cleared");
        rd(11'h7FC, 32'h0, "R12 last descriptor cleared");
        wr(11'h404, 32'hDEAD_BEEF);
        wr(11'h7FC, 32'h1234_5678);
        rd(11'h404, 32'hDEAD_BEEF, "R7 descriptor word 1");
        rd(11'h7FC, 32'h1234_5678, "R7 descriptor word 255");
        rd(11'h400, 32'h0,         "R7 neighbour untouched");

        // R8 unmapped
        wr(11'h100, 32'hFFFF_FFFF);
        rd(11'h100, 32'h0, "R8 unmapped read zero");
        rd(11'h050, 32'h0, "R8 gap read zero");
        rd(A_MODE, 32'h0000_A000, "R8 write left mode alone");

        // R11 enables
        wr(A_MODE, 32'h0000_0003);
        chk({tx_en, rx_en}, 2'b11, "R11 both enabled");
        wr(A_MODE, 32'h0000_0002);
        chk({tx_en, rx_en}, 2'b10, "R11 tx only");

        // R2 limits
        wr(A_PLEN, 32'h0040_0200);
        chk(min_len, 16'd64,  "R2 min update");
        chk(max_len, 16'd512, "R2 max update");

        // R3 / R4 events
        @(posedge clk); #1; irq_set = 7'b000_0101;
        @(posedge clk); #1; irq_set = '0;
        rd(A_SRC, 32'h5, "R3 flags set by events");
        @(posedge clk); #1;
        chk(irq, 0, "R4 masked off");
        wr(A_MASK, 32'h4);
        chk(irq, 1, "R4 enabled flag raises irq");
        wr(A_SRC, 32'h4);
        rd(A_SRC, 32'h1, "R3 only written one cleared");
        @(posedge clk); #1;
        chk(irq, 0, "R4 irq drops after clear");
        wr(A_SRC, 32'h0);
        rd(A_SRC, 32'h1, "R3 zero write keeps flags");
        @(posedge clk); #1;
        addr = A_SRC; wdata = 32'h1; we = 1'b1; irq_set = 7'b000_0001;
        @(posedge clk); #1;
        we = 1'b0; irq_set = '0;
        rd(A_SRC, 32'h1, "R3 set wins over clear");
        wr(A_SRC, 32'h1);
        rd(A_SRC, 32'h0, "R3 final clear");

        // R5 descriptor count
        wr(A_TXCNT, 32'h0000_1234);
        rd(A_TXCNT, 32'h34, "R5 count low byte kept");
        @(posedge clk); #1;
        chk(rx_ptr, 9'h068, "R5 rx pointer reloaded");
        chk(tx_cnt, 8'h34,  "R5 tx count output");

        // R6 station address
        wr(A_MAC0, 32'h1122_3344);
        wr(A_MAC1, 32'hAABB_CCDD);
        rd(A_MAC1, 32'h0000_CCDD, "R6 station word1 masked");
        rd(A_MAC0, 32'h1122_3344, "R6 station word0");
        @(posedge clk); #1;
        chk(st_addr, 48'hCCDD_1122_3344, "R6 station output");
        wr(A_HASH0, 32'hA5A5_0F0F);
        rd(A_HASH0, 32'hA5A5_0F0F, "R1 hash0 writable");
        wr(A_IPGT, 32'h55);

        // R9 / R10 soft reset
        wr(A_MODE, 32'h0000_0803);
        chk(eng_rst, 1, "R9 scrub started");
        rd(A_MODE, 32'h0, "R10 read during scrub zero");
        wr(A_IPGT, 32'h77);
        n = 3;
        while (eng_rst && n < 1000) begin @(posedge clk); #1; n++; end
        chk(n, 256, "R9 scrub length");
        rd(A_MODE,  32'h0000_A000, "R9 mode restored");
        rd(A_IPGT,  32'h12,        "R10 write during scrub ignored");
        rd(A_PLEN,  32'h003C_0600, "R9 length restored");
        rd(A_TXCNT, 32'h40,        "R9 count restored");
        rd(A_MASK,  32'h0,         "R9 mask cleared");
        rd(A_MAC0,  32'h0,         "R9 station cleared");
        rd(11'h404, 32'h0,         "R9 descriptor scrubbed");
        @(posedge clk); #1;
        chk(rx_ptr, 9'h80, "R9 rx pointer restored");
        chk({tx_en, rx_en}, 2'b00, "R9 enables restored");
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule